// File: doc/BRIEF.md
# Concurrent Write Conflict Resolver

This block sits between a set of processor write ports and a shared memory. In each cycle every port may offer one write, made of a valid bit, a target address and a data word. The block groups the valid writes by target address. For each group it works out the one value, if any, that the memory should receive. A run-time policy input decides how a collision between ports is settled: it may be forbidden, settled by port rank, allowed only when all the values agree, settled by a fixed pick, or settled by reducing all the colliding values with a chosen operator.

There is one commit slot per input port. A group is reported on the slot of its lowest-index member, and the other members' slots stay idle. The commits and two rule-violation flags leave through one register stage, so a write offered in cycle t appears in cycle t+1.

Top module: `cw_resolver`

## Requirements
- R1: While `rst_n` is low, all of the following are 0 on the next clock edge: `cm_en`, `cm_addr`, `cm_data`, `excl_err` and `cmn_mismatch`.
- R2: A valid port whose address no other valid port shares appears one cycle later on its own slot. Its `cm_en` bit is 1 and it carries its address and data unchanged, in every policy.
- R3: Valid ports that share an address are collapsed onto the slot of the lowest-index member. The slots of the other members show `cm_en`=0, and no two enabled slots ever carry the same address.
- R4: With policy 0 (exclusive), a shared address raises `excl_err` one cycle later and commits nothing for that address. Addresses with a single writer still commit.
- R5: With policy 1 (priority), the data from the highest-index colliding port is committed.
- R6: With policy 2 (common), colliding ports that all carry the same data commit that data. If their data differ, nothing is committed for that address and `cmn_mismatch` is raised one cycle later.
- R7: With policy 3 (arbitrary), the data from the lowest-index colliding port is committed. Policy codes 5, 6 and 7 behave the same as policy 3.
- R8: With policy 4 (combining), operator 0 (SUM) and operator 1 (PRODUCT) reduce all colliding values and wrap modulo 2^DW. Operator code 7 behaves as SUM.
- R9: In combining mode, operator 2 (MAX) and operator 3 (MIN) compare the values as unsigned numbers.
- R10: In combining mode, operators 4, 5 and 6 reduce the colliding values with bitwise AND, OR and XOR, in that order.
- R11: Ports whose valid bit is 0 take no part in any group. They cannot cause an error, a mismatch or a change to a committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | N | One write-valid bit per port |
| wr_addr | input | N*AW | Port addresses, port i at bits [i*AW +: AW] |
| wr_data | input | N*DW | Port data, port i at bits [i*DW +: DW] |
| mode | input | 3 | Collision policy (0 exclusive, 1 priority, 2 common, 3 arbitrary, 4 combining) |
| op | input | 3 | Combining operator (0 SUM, 1 PRODUCT, 2 MAX, 3 MIN, 4 AND, 5 OR, 6 XOR) |
| cm_en | output | N | Commit enable per slot |
| cm_addr | output | N*AW | Commit address per slot |
| cm_data | output | N*DW | Commit data per slot |
| excl_err | output | 1 | A collision occurred under the exclusive policy |
| cmn_mismatch | output | 1 | Colliding values differed under the common policy |

## Verification
A wrong group leader would show up on the very next cycle: either two enabled slots carrying the same address, or a group reported on a slot other than that of its lowest-index member. A wrong reduction or a wrong selection would show up as a wrong `cm_data` value one cycle after the stimulus. The collision sets are chosen so that each operator gives a value no other operator gives. The flags are checked against the cycle's policy, so a flag raised under the wrong policy is caught at once.

// File: rtl/cw_resolver.sv
module cw_resolver #(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  wr_valid,
  input  logic [N*AW-1:0] wr_addr,
  input  logic [N*DW-1:0] wr_data,
  input  logic [2:0]    mode,
  input  logic [2:0]    op,
  output logic [N-1:0]  cm_en,
  output logic [N*AW-1:0] cm_addr,
  output logic [N*DW-1:0] cm_data,
  output logic          excl_err,
  output logic          cmn_mismatch
);
  localparam logic [2:0] M_EXCL = 3'd0, M_PRIO = 3'd1, M_COMN = 3'd2, M_COMB = 3'd4;

  logic [N-1:0]    n_en;
  logic [N*AW-1:0] n_addr;
  logic [N*DW-1:0] n_data;
  logic            n_err, n_mis;

  always_comb begin
    logic          lead, multi, eq, hit;
    logic [DW-1:0] own, dj, s_sum, s_prod, s_max, s_min, s_and, s_or, s_xor, s_hi, res;
    n_en = '0; n_addr = '0; n_data = '0; n_err = 1'b0; n_mis = 1'b0;
    for (int i = 0; i < N; i++) begin
      own  = wr_data[i*DW +: DW];
      lead = wr_valid[i];
      for (int j = 0; j < i; j++)
        if (wr_valid[j] && wr_addr[j*AW +: AW] == wr_addr[i*AW +: AW]) lead = 1'b0;
      multi = 1'b0; eq = 1'b1;
      s_sum = '0; s_prod = DW'(1); s_max = '0; s_min = '1;
      s_and = '1; s_or = '0; s_xor = '0; s_hi = own;
      for (int j = 0; j < N; j++) begin
        dj  = wr_data[j*DW +: DW];
        hit = wr_valid[j] && wr_addr[j*AW +: AW] == wr_addr[i*AW +: AW];
        if (hit) begin
          if (j != i) multi = 1'b1;
          if (dj != own) eq = 1'b0;
          s_sum  = s_sum + dj;
          s_prod = s_prod * dj;
          if (dj > s_max) s_max = dj;
          if (dj < s_min) s_min = dj;
          s_and = s_and & dj;
          s_or  = s_or | dj;
          s_xor = s_xor ^ dj;
          s_hi  = dj;
        end
      end
      case (mode)
        M_PRIO:  res = s_hi;
        M_COMB:
          case (op)
            3'd1:    res = s_prod;
            3'd2:    res = s_max;
            3'd3:    res = s_min;
            3'd4:    res = s_and;
            3'd5:    res = s_or;
            3'd6:    res = s_xor;
            default: res = s_sum;
          endcase
        default: res = own;
      endcase
      if (lead && multi && mode == M_EXCL) n_err = 1'b1;
      if (lead && !eq && mode == M_COMN) n_mis = 1'b1;
      if (lead && !(multi && mode == M_EXCL) && !(!eq && mode == M_COMN)) begin
        n_en[i] = 1'b1;
        n_addr[i*AW +: AW] = wr_addr[i*AW +: AW];
        n_data[i*DW +: DW] = res;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cm_en <= '0; cm_addr <= '0; cm_data <= '0;
      excl_err <= 1'b0; cmn_mismatch <= 1'b0;
    end else begin
      cm_en <= n_en; cm_addr <= n_addr; cm_data <= n_data;
      excl_err <= n_err; cmn_mismatch <= n_mis;
    end
  end
endmodule

// File: rtl/cw_resolver_chk.sv
module cw_resolver_chk #(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    wr_valid,
  input logic [N*AW-1:0] wr_addr,
  input logic [2:0]      mode,
  input logic [N-1:0]    cm_en,
  input logic [N*AW-1:0] cm_addr,
  input logic            excl_err,
  input logic            cmn_mismatch
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    assert_commit_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cm_en[i] |-> $past(wr_valid[i]));
    assert_commit_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cm_en[i] |-> cm_addr[i*AW +: AW] == $past(wr_addr[i*AW +: AW]));
    for (genvar j = i + 1; j < N; j++) begin : g_pair
      assert_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cm_en[i] && cm_en[j] && cm_addr[i*AW +: AW] == cm_addr[j*AW +: AW]));
    end
  end

  assert_excl_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    excl_err |-> $past(mode) == 3'd0);
  assert_common_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmn_mismatch |-> $past(mode) == 3'd2);
endmodule

bind cw_resolver cw_resolver_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .mode(mode),
  .cm_en(cm_en), .cm_addr(cm_addr), .excl_err(excl_err), .cmn_mismatch(cmn_mismatch)
);

// File: tb/test_cw_resolver.sv
module test_cw_resolver;
  localparam int N = 4, AW = 4, DW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] wr_valid = '0;
  logic [N*AW-1:0] wr_addr = '0;
  logic [N*DW-1:0] wr_data = '0;
  logic [2:0] mode = '0, op = '0;
  logic [N-1:0] cm_en;
  logic [N*AW-1:0] cm_addr;
  logic [N*DW-1:0] cm_data;
  logic excl_err, cmn_mismatch;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  cw_resolver #(.N(N), .AW(AW), .DW(DW)) i_cw_resolver (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .op(op), .cm_en(cm_en), .cm_addr(cm_addr), .cm_data(cm_data),
    .excl_err(excl_err), .cmn_mismatch(cmn_mismatch));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic port(input int i, input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_valid[i] = v; wr_addr[i*AW +: AW] = a; wr_data[i*DW +: DW] = d;
  endtask

  task automatic fire(input logic [2:0] m, input logic [2:0] o);
    mode = m; op = o;
    @(negedge clk);
    wr_valid = '0;
  endtask

  function automatic logic [DW-1:0] slot_d(input int i);
    return cm_data[i*DW +: DW];
  endfunction

  task automatic t_reset;
    @(negedge clk);
    port(0, 1, 4'd1, 8'h11); port(1, 1, 4'd1, 8'h22); mode = 3'd0;
    @(negedge clk);
    chk("R1 en", cm_en, 0); chk("R1 err", excl_err, 0);
    chk("R1 mis", cmn_mismatch, 0); chk("R1 data", cm_data, 0);
    wr_valid = '0; rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_single;
    for (int m = 0; m < 5; m++) begin
      port(0, 1, 4'd1, 8'h11); port(1, 1, 4'd2, 8'h22);
      port(2, 1, 4'd3, 8'h33); port(3, 1, 4'd4, 8'h44);
      fire(3'(m), 3'd1);
      chk("R2 en", cm_en, 4'hF);
      chk("R2 addr", cm_addr, 16'h4321);
      chk("R2 data", cm_data, 32'h44332211);
      chk("R2 flags", {excl_err, cmn_mismatch}, 0);
      @(negedge clk);
      chk("R2 idle", cm_en, 0);
    end
  endtask

  task automatic t_invalid;
    port(0, 1, 4'd6, 8'h5A); port(1, 0, 4'd6, 8'h01);
    port(2, 1, 4'd7, 8'h77); port(3, 0, 4'd6, 8'h02);
    fire(3'd0, 3'd0);
    chk("R11 en", cm_en, 4'b0101); chk("R11 err", excl_err, 0);
    chk("R11 d0", slot_d(0), 8'h5A);
    port(0, 1, 4'd6, 8'h5A); port(1, 0, 4'd6, 8'h99);
    fire(3'd2, 3'd0);
    chk("R11 mis", cmn_mismatch, 0); chk("R11 c0", slot_d(0), 8'h5A);
  endtask

  task automatic t_excl;
    port(0, 1, 4'd7, 8'h10); port(1, 1, 4'd3, 8'h20);
    port(2, 1, 4'd7, 8'h30); port(3, 1, 4'd9, 8'h40);
    fire(3'd0, 3'd0);
    chk("R4 err", excl_err, 1); chk("R4 en", cm_en, 4'b1010);
    chk("R4 d1", slot_d(1), 8'h20); chk("R4 d3", slot_d(3), 8'h40);
    @(negedge clk);
    chk("R4 clear", excl_err, 0);
  endtask

  task automatic t_prio;
    port(0, 1, 4'd5, 8'd10); port(1, 1, 4'd5, 8'd20);
    port(2, 1, 4'd5, 8'd30); port(3, 1, 4'd5, 8'd40);
    fire(3'd1, 3'd0);
    chk("R3 en", cm_en, 4'b0001); chk("R3 addr", cm_addr[AW-1:0], 4'd5);
    chk("R5 d", slot_d(0), 8'd40);
    port(0, 1, 4'd2, 8'd1); port(1, 1, 4'd9, 8'd2); port(2, 1, 4'd9, 8'd3);
    fire(3'd1, 3'd0);
    chk("R3 lead", cm_en, 4'b0011); chk("R5 d1", slot_d(1), 8'd3);
  endtask

  task automatic t_common;
    port(1, 1, 4'd4, 8'hAB); port(2, 1, 4'd4, 8'hAB); port(3, 1, 4'd4, 8'hAB);
    fire(3'd2, 3'd0);
    chk("R6 en", cm_en, 4'b0010); chk("R6 d", slot_d(1), 8'hAB); chk("R6 ok", cmn_mismatch, 0);
    port(0, 1, 4'd4, 8'hAB); port(1, 1, 4'd4, 8'hAB); port(2, 1, 4'd4, 8'hAC);
    port(3, 1, 4'd1, 8'h07);
    fire(3'd2, 3'd0);
    chk("R6 en bad", cm_en, 4'b1000); chk("R6 mis", cmn_mismatch, 1);
    chk("R6 d3", slot_d(3), 8'h07);
  endtask

  task automatic t_arb;
    port(0, 1, 4'd2, 8'd9); port(1, 1, 4'd6, 8'd70);
    port(2, 1, 4'd6, 8'd80); port(3, 1, 4'd6, 8'd90);
    fire(3'd3, 3'd0);
    chk("R7 en", cm_en, 4'b0011); chk("R7 d", slot_d(1), 8'd70);
    port(0, 1, 4'd3, 8'd5); port(1, 1, 4'd3, 8'd6);
    fire(3'd7, 3'd0);
    chk("R7 mode7", slot_d(0), 8'd5);
  endtask

  task automatic coll4(input logic [2:0] o, input logic [DW-1:0] exp, input string tag);
    port(0, 1, 4'd8, 8'd200); port(1, 1, 4'd8, 8'd100);
    port(2, 1, 4'd8, 8'd3);   port(3, 1, 4'd8, 8'd1);
    fire(3'd4, o);
    chk(tag, {cm_en, slot_d(0)}, {4'b0001, exp});
  endtask

  task automatic coll2(input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [2:0] o, input logic [DW-1:0] exp, input string tag);
    port(1, 1, 4'd3, a); port(3, 1, 4'd3, b);
    fire(3'd4, o);
    chk(tag, {cm_en, slot_d(1)}, {4'b0010, exp});
  endtask

  task automatic t_comb;
    coll4(3'd0, 8'h30, "R8 sum wrap");
    coll4(3'd1, 8'h60, "R8 prod wrap");
    coll4(3'd7, 8'h30, "R8 op7 sum");
    coll4(3'd2, 8'd200, "R9 max");
    coll4(3'd3, 8'd1, "R9 min");
    coll2(8'h80, 8'h7F, 3'd2, 8'h80, "R9 max unsigned");
    coll2(8'h80, 8'h7F, 3'd3, 8'h7F, "R9 min unsigned");
    coll2(8'hF0, 8'h3C, 3'd4, 8'h30, "R10 and");
    coll2(8'hF0, 8'h3C, 3'd5, 8'hFC, "R10 or");
    coll2(8'hF0, 8'h3C, 3'd6, 8'hCC, "R10 xor");
  endtask

  initial begin
    t_reset;
    t_single;
    t_invalid;
    t_excl;
    t_prio;
    t_common;
    t_arb;
    t_comb;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total++; fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule